// File: doc/BRIEF.md
# Round-Robin Output-Current Calibration Scheduler

This block belongs in a memory controller. It keeps the output-current calibration of every device on one shared channel up to date. Calibration of this kind cannot be sent to all devices at once, because the returned calibration packets would collide on the data lanes. The block therefore divides the calibration period into equal intervals, one per device. In each interval it runs one calibration transaction aimed at a single device, and it moves on to the next device after every completed transaction.

A transaction consists of four column-extension command slots. The block obtains each slot from the channel's command arbiter through a request/grant handshake. Every slot carries a calibrate opcode, and the fourth slot also carries a sample opcode. A fixed number of cycles after the sampling slot, the addressed device returns its calibration packet. The block reads two data lanes of that packet and decodes a hot-temperature flag, which it keeps per device. While a transaction is in progress, it tells the read path which device must not return read data, so that same-device reads stay clear of the calibration packet.

Top module: `iol_cal_scheduler`

## Requirements
- R1: A transaction takes exactly four granted slots. `slot_req` stays high from its rise until the fourth grant and drops in the cycle after that grant. Each grant (`slot_req` and `slot_gnt` high in one cycle) makes `cmd_vld` and `cmd_cal` high in the following cycle.
- R2: `cmd_sam` is high only together with the command of the fourth slot of a transaction and is low for the first three.
- R3: All four commands of a transaction carry the same `cmd_dev`. Successive transactions address devices 0, 1, ..., NUM_DEV-1, 0, ... in that order, and the id advances only after a transaction completes.
- R4: With INTERVAL = PERIOD / NUM_DEV, the first `slot_req` rises INTERVAL cycles after the first cycle out of reset. Every later `slot_req` rises INTERVAL+1 cycles after the cycle of the previous transaction's fourth grant, however late that grant was.
- R5: With NUM_DEV = 0 the block never raises `slot_req`, `cmd_vld` or `rd_hold`.
- R6: The data lanes are sampled in the cycle exactly CAC_LAT cycles after the cycle in which the sampling command is output. Bit d of `hot_flags` (d = the transaction's device id) then becomes `!dq_temp_n & dq_cc` in the next cycle. The other bits keep their values, and the lanes are ignored in every other cycle.
- R7: `rd_hold` is high with `rd_hold_dev` equal to the transaction's device from the cycle `slot_req` rises through POST_GAP cycles after the sampling cycle, and low in the cycle after that.
- R8: During reset and in the first cycle after it, `slot_req`, `cmd_vld`, `cmd_sam`, `rd_hold` and `hot_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_req | output | 1 | Request for a column-extension command slot |
| slot_gnt | input | 1 | Arbiter grant of the requested slot |
| cmd_vld | output | 1 | A calibration command occupies the slot this cycle |
| cmd_cal | output | 1 | Calibrate opcode bit |
| cmd_sam | output | 1 | Sample opcode bit (fourth slot only) |
| cmd_dev | output | DEV_W | Target device id of the command |
| dq_temp_n | input | 1 | Returned temperature lane, low means hot |
| dq_cc | input | 1 | Returned current-control lane, high when a device answered |
| rd_hold | output | 1 | Reads from `rd_hold_dev` must be held off |
| rd_hold_dev | output | DEV_W | Device currently being calibrated |
| hot_flags | output | max(NUM_DEV,1) | Per-device hot-temperature flags |

## Verification
A command is due one cycle after its grant. The next request is due INTERVAL+1 cycles after the fourth grant, and the hot flag CAC_LAT+1 cycles after the sampling command. The read hold must fall POST_GAP+1 cycles after the sampling cycle. The bench keeps a cycle counter, records the grant and command cycles of each transaction, and compares each output only in the exact cycle derived from these counts, sampling on the falling edge. To catch a sampling instant that is off by one, the data lanes carry the opposite of the expected flag in every cycle except the one the device is due to answer. Grant delays vary per slot, so the restart rule is checked against grants that come late.

// File: rtl/iolcal_pkg.sv
package iolcal_pkg;

  localparam int unsigned PKTS_PER_TXN = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_e;

  // Cycles between transaction starts; a zero device count keeps a legal width.
  function automatic int unsigned slot_interval(input int unsigned period,
                                                input int unsigned ndev);
    int unsigned r;
    r = (ndev == 0) ? period : period / ndev;
    return (r == 0) ? 1 : r;
  endfunction

  // Absent device drives the current lane low, so it never reads as hot.
  function automatic logic hot_decode(input logic temp_n, input logic cc);
    return ~temp_n & cc;
  endfunction

  function automatic int unsigned slots_of(input int unsigned ndev);
    return (ndev == 0) ? 1 : ndev;
  endfunction

endpackage

// File: rtl/iolcal_interval_timer.sv
module iolcal_interval_timer #(
  parameter int unsigned INTERVAL = 100,
  localparam int unsigned CNT_W = $clog2(INTERVAL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic due
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;

  // Saturates at LAST until the sequencer restarts it on the final grant.
  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (restart)       cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign due = (cnt_q == LAST);

endmodule

// File: rtl/iolcal_burst_seq.sv
module iolcal_burst_seq
  import iolcal_pkg::*;
#(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned DEV_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             due,
  input  logic             slot_gnt,
  input  logic             txn_done,
  output logic             slot_req,
  output logic             last_gnt,
  output logic             cmd_vld,
  output logic             cmd_sam,
  output logic [DEV_W-1:0] cmd_dev,
  output logic             busy,
  output logic [DEV_W-1:0] dev
);

  localparam bit               ENABLE   = (NUM_DEV != 0);
  localparam int unsigned      LAST_DEV = (NUM_DEV == 0) ? 0 : NUM_DEV - 1;
  localparam logic [DEV_W-1:0] DEV_TOP  = DEV_W'(LAST_DEV);
  localparam logic [1:0]       PKT_TOP  = 2'(PKTS_PER_TXN - 1);

  seq_state_e       state_q;
  logic [1:0]       pkt_q;
  logic [DEV_W-1:0] dev_q;
  logic             gnt_take;
  logic             vld_q, sam_q;
  logic [DEV_W-1:0] cdev_q;

  assign gnt_take = (state_q == ST_REQ) && slot_gnt;
  assign last_gnt = gnt_take && (pkt_q == PKT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pkt_q   <= '0;
      dev_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (due && ENABLE) begin
          state_q <= ST_REQ;
          pkt_q   <= '0;
        end
        ST_REQ: if (gnt_take) begin
          pkt_q <= pkt_q + 1'b1;
          if (last_gnt) state_q <= ST_WAIT;
        end
        ST_WAIT: if (txn_done) begin
          state_q <= ST_IDLE;
          dev_q   <= (dev_q == DEV_TOP) ? '0 : dev_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Command slot is presented the cycle after its grant.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      sam_q  <= 1'b0;
      cdev_q <= '0;
    end else begin
      vld_q  <= gnt_take;
      sam_q  <= last_gnt;
      cdev_q <= dev_q;
    end
  end

  assign slot_req = (state_q == ST_REQ);
  assign busy     = (state_q != ST_IDLE);
  assign dev      = dev_q;
  assign cmd_vld  = vld_q;
  assign cmd_sam  = sam_q;
  assign cmd_dev  = cdev_q;

endmodule

// File: rtl/iolcal_capture.sv
module iolcal_capture
  import iolcal_pkg::*;
#(
  parameter int unsigned SLOTS    = 4,
  parameter int unsigned DEV_W    = 2,
  parameter int unsigned CAC_LAT  = 8,
  parameter int unsigned POST_GAP = 3,
  localparam int unsigned LAT_W  = $clog2(CAC_LAT + 1),
  localparam int unsigned POST_W = $clog2(POST_GAP + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sam_seen,
  input  logic [DEV_W-1:0] dev,
  input  logic             dq_temp_n,
  input  logic             dq_cc,
  output logic             samp_fire,
  output logic             txn_done,
  output logic [SLOTS-1:0] hot_flags
);

  logic              pend_q;
  logic [LAT_W-1:0]  lat_q;
  logic [POST_W-1:0] post_q;
  logic              hot_now;

  assign samp_fire = pend_q && (lat_q == '0);
  assign hot_now   = hot_decode(dq_temp_n, dq_cc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      lat_q  <= '0;
    end else if (sam_seen) begin
      pend_q <= 1'b1;
      lat_q  <= LAT_W'(CAC_LAT - 1);
    end else if (samp_fire) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      lat_q <= lat_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              post_q <= '0;
    else if (samp_fire)      post_q <= POST_W'(POST_GAP);
    else if (post_q != '0)   post_q <= post_q - 1'b1;
  end

  generate
    if (POST_GAP == 0) begin : g_no_gap
      assign txn_done = samp_fire;
    end else begin : g_gap
      assign txn_done = (post_q == POST_W'(1));
    end
  endgenerate

  for (genvar i = 0; i < SLOTS; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                                      hot_flags[i] <= 1'b0;
      else if (samp_fire && (dev == DEV_W'(i)))        hot_flags[i] <= hot_now;
    end
  end

endmodule

// File: rtl/iol_cal_scheduler.sv
module iol_cal_scheduler
  import iolcal_pkg::*;
#(
  parameter int unsigned PERIOD   = 400,
  parameter int unsigned NUM_DEV  = 4,
  parameter int unsigned CAC_LAT  = 8,
  parameter int unsigned POST_GAP = 3,
  localparam int unsigned SLOTS = slots_of(NUM_DEV),
  localparam int unsigned DEV_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             slot_req,
  input  logic             slot_gnt,
  output logic             cmd_vld,
  output logic             cmd_cal,
  output logic             cmd_sam,
  output logic [DEV_W-1:0] cmd_dev,
  input  logic             dq_temp_n,
  input  logic             dq_cc,
  output logic             rd_hold,
  output logic [DEV_W-1:0] rd_hold_dev,
  output logic [SLOTS-1:0] hot_flags
);

  localparam int unsigned INTERVAL = slot_interval(PERIOD, NUM_DEV);

  logic             due, last_gnt, txn_done, samp_fire, busy;
  logic [DEV_W-1:0] dev;

  iolcal_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(last_gnt), .due(due)
  );

  iolcal_burst_seq #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .due(due), .slot_gnt(slot_gnt),
    .txn_done(txn_done), .slot_req(slot_req), .last_gnt(last_gnt),
    .cmd_vld(cmd_vld), .cmd_sam(cmd_sam), .cmd_dev(cmd_dev),
    .busy(busy), .dev(dev)
  );

  iolcal_capture #(
    .SLOTS(SLOTS), .DEV_W(DEV_W), .CAC_LAT(CAC_LAT), .POST_GAP(POST_GAP)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .sam_seen(cmd_vld && cmd_sam), .dev(dev),
    .dq_temp_n(dq_temp_n), .dq_cc(dq_cc), .samp_fire(samp_fire),
    .txn_done(txn_done), .hot_flags(hot_flags)
  );

  assign cmd_cal     = cmd_vld;
  assign rd_hold     = busy;
  assign rd_hold_dev = dev;

endmodule

// File: rtl/iolcal_sva.sv
module iolcal_sva #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned DEV_W   = 2,
  parameter int unsigned SLOTS   = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_req,
  input logic             slot_gnt,
  input logic             cmd_vld,
  input logic             cmd_cal,
  input logic             cmd_sam,
  input logic [DEV_W-1:0] cmd_dev,
  input logic             rd_hold,
  input logic [DEV_W-1:0] rd_hold_dev,
  input logic [SLOTS-1:0] hot_flags,
  input logic             samp_fire
);

  a_r1_cmd_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && slot_gnt) |=> (cmd_vld && cmd_cal));

  a_r1_cmd_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> $past(slot_req && slot_gnt));

  a_r1_req_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_req && !slot_gnt) |=> slot_req);

  a_r2_sam_with_cal: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_sam |-> (cmd_vld && cmd_cal));

  a_r3_dev_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (int'(cmd_dev) < int'(NUM_DEV)));

  a_r3_cmd_dev_matches_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |-> (rd_hold && (cmd_dev == rd_hold_dev)));

  a_r5_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_DEV == 0) |-> !(slot_req || rd_hold));

  a_r6_flag_write_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_flags != $past(hot_flags)) |-> $past(samp_fire));

  a_r6_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hot_flags ^ $past(hot_flags)) <= 1);

  a_r7_req_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req |-> rd_hold);

  a_r7_dev_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hold && $past(rd_hold)) |-> $stable(rd_hold_dev));

endmodule

bind iol_cal_scheduler iolcal_sva #(
  .NUM_DEV(NUM_DEV), .DEV_W(DEV_W), .SLOTS(SLOTS)
) u_sva (
  .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .slot_gnt(slot_gnt),
  .cmd_vld(cmd_vld), .cmd_cal(cmd_cal), .cmd_sam(cmd_sam), .cmd_dev(cmd_dev),
  .rd_hold(rd_hold), .rd_hold_dev(rd_hold_dev), .hot_flags(hot_flags),
  .samp_fire(samp_fire)
);

// File: tb/iol_cal_scheduler_tb.sv
module iol_cal_scheduler_tb;

  localparam int PERIOD = 120;
  localparam int NDEV   = 3;
  localparam int CAC    = 5;
  localparam int POST   = 3;
  localparam int IVL    = PERIOD / NDEV;
  localparam int NTXN   = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_gnt = 1'b0;
  logic       dq_temp_n = 1'b1;
  logic       dq_cc = 1'b0;
  logic       slot_req, cmd_vld, cmd_cal, cmd_sam, rd_hold;
  logic [1:0] cmd_dev, rd_hold_dev;
  logic [2:0] hot_flags;

  logic       o_req, o_vld, o_cal, o_sam, o_hold;
  logic       o_dev, o_hdev, o_hot;

  int cyc = 0;
  int nchk = 0;
  int nerr = 0;
  int off_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  iol_cal_scheduler #(.PERIOD(PERIOD), .NUM_DEV(NDEV), .CAC_LAT(CAC), .POST_GAP(POST)) u_dut (
    .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .slot_gnt(slot_gnt),
    .cmd_vld(cmd_vld), .cmd_cal(cmd_cal), .cmd_sam(cmd_sam), .cmd_dev(cmd_dev),
    .dq_temp_n(dq_temp_n), .dq_cc(dq_cc), .rd_hold(rd_hold),
    .rd_hold_dev(rd_hold_dev), .hot_flags(hot_flags)
  );

  iol_cal_scheduler #(.PERIOD(PERIOD), .NUM_DEV(0), .CAC_LAT(CAC), .POST_GAP(POST)) u_off (
    .clk(clk), .rst_n(rst_n), .slot_req(o_req), .slot_gnt(1'b1),
    .cmd_vld(o_vld), .cmd_cal(o_cal), .cmd_sam(o_sam), .cmd_dev(o_dev),
    .dq_temp_n(1'b0), .dq_cc(1'b1), .rd_hold(o_hold),
    .rd_hold_dev(o_hdev), .hot_flags(o_hot)
  );

  always @(negedge clk)
    if (rst_n && (o_req || o_vld || o_sam || o_hold)) off_bad++;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  initial begin
    int rel, gcyc, last_g, tcyc, scyc, rise;
    bit exp_hot;
    bit [2:0] model;
    model = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 req", int'(slot_req), 0);
    chk("R8 cmd", int'(cmd_vld | cmd_sam), 0);
    chk("R8 hold", int'(rd_hold), 0);
    chk("R8 hot", int'(hot_flags), 0);
    rst_n = 1'b1;
    rel = cyc;
    @(negedge clk);
    chk("R8 req after reset", int'(slot_req), 0);
    chk("R8 hold after reset", int'(rd_hold), 0);
    last_g = 0;
    for (int k = 0; k < NTXN; k++) begin
      while (!slot_req) @(negedge clk);
      rise = cyc;
      // R4: interval pacing, restart from the final grant
      if (k == 0) chk("R4 first request", rise - rel, IVL);
      else        chk("R4 request after grant", rise - last_g, IVL + 1);
      chk("R7 hold at request", int'(rd_hold), 1);
      chk("R7 hold device", int'(rd_hold_dev), k % NDEV);
      for (int p = 0; p < 4; p++) begin
        for (int d = 0; d < (k + p) % 3; d++) begin
          chk("R1 request held", int'(slot_req), 1);
          @(negedge clk);
        end
        slot_gnt = 1'b1;
        gcyc = cyc;
        @(negedge clk);
        slot_gnt = 1'b0;
        chk("R1 command after grant", int'(cmd_vld & cmd_cal), 1);
        chk("R2 sample only on fourth", int'(cmd_sam), (p == 3) ? 1 : 0);
        chk("R3 device id", int'(cmd_dev), k % NDEV);
        chk("R1 request after grant", int'(slot_req), (p == 3) ? 0 : 1);
      end
      last_g = gcyc;
      tcyc = cyc;
      scyc = tcyc + CAC;
      exp_hot = ~k[0] & k[1];
      // decoy lanes decode to the opposite flag
      dq_temp_n = exp_hot; dq_cc = 1'b1;
      while (cyc < scyc) begin
        @(negedge clk);
        chk("R7 hold during wait", int'(rd_hold), 1);
        if (cyc == scyc) begin
          chk("R6 flags before sample", int'(hot_flags), int'(model));
          dq_temp_n = k[0]; dq_cc = k[1];
        end
      end
      @(negedge clk);
      dq_temp_n = exp_hot; dq_cc = 1'b1;
      model[k % NDEV] = exp_hot;
      chk("R6 hot flags", int'(hot_flags), int'(model));
      for (int i = 1; i <= POST; i++) begin
        chk("R7 hold in post gap", int'(rd_hold), 1);
        chk("R7 hold device in gap", int'(rd_hold_dev), k % NDEV);
        @(negedge clk);
      end
      chk("R7 hold released", int'(rd_hold), 0);
      chk("R6 flags steady after sample", int'(hot_flags), int'(model));
      chk("R1 no request after transaction", int'(slot_req), 0);
    end
    // R5: disabled instance stayed silent
    chk("R5 disabled activity", off_bad, 0);
    chk("R5 disabled flags", int'(o_hot), 0);
    done = 1'b1;
    finish_run();
  end

endmodule